// File: doc/BRIEF.md
# Training-Sequence Lane Configuration Learner

This block sits beside the receivers of a passive link observer. Each cycle it takes one aligned 10-bit code group from every physical lane. It follows the training ordered sets that the two ends exchange while the link comes up. From those sets it works out two things: which physical lanes arrive with swapped differential polarity, and whether the lane order is reversed. It reports the result as a per-lane polarity mask and a single reversal bit.

A decision is accepted only after a run of identical, well-formed second-type training sets on every active lane. A commit strobe can freeze an accepted decision into a fixed configuration. While fixed mode is selected, the frozen values drive the outputs. The observer therefore has a valid setup straight after a link interruption, even before any new training is seen. Link-state tracking and packet decoding are handled elsewhere.

Top module: `lane_cfg_learner`

## Requirements
- R1: After a synchronous reset, `pol_mask` and `reversed` are 0 and both `learned` and `locked` are low.
- R2: A training set on one lane is a sequence of `TS_LEN` code groups on `cg_valid` cycles, in this order: a comma group (0011111010 or its complement 1100000101), then a lane-number group `{5'b10100, lane[4:0]}`, then `TS_LEN-2` identifier groups. The identifier is 0101010101 for a first-type set and 1010010101 for a second-type set. Groups outside a set, and cycles with `cg_valid` low, are ignored.
- R3: A lane counts as inverted when its identifier groups arrive as the bitwise complement of the expected code. Its lane-number group is then complemented before it is read. `pol_mask` bit p refers to physical lane p. Bits at or above `width` are 0.
- R4: Reversal is set when the corrected lane number on physical lane 0 equals `width-1` (with `width` > 1), and cleared when that number is 0. In a valid set, every active physical lane p must carry p when not reversed, or `width-1-p` when reversed. Any other numbering makes the set inconsistent. With `width` = 1 the result is never reversed.
- R5: `learned` rises, and the decision takes effect, once `RUN_LEN` (default 8) consecutive second-type sets agree in polarity mask and reversal on all active lanes. First-type sets neither add to the run nor break it.
- R6: The run restarts on any of the following: an invalid identifier, mixed identifiers within one set, a comma arriving before a set completes, active lanes that do not finish a set in the same cycle, or a set whose polarity or reversal differs from the run's candidate.
- R7: When no valid run has been seen, `learned` stays low and the outputs keep their previous values. Once high, `learned` stays high. An earlier decision stays in effect until a complete new run replaces it.
- R8: A `commit` pulse while `mode_fixed` is high and `learned` is high copies the learned decision into the fixed registers and sets `locked`. A `commit` pulse while `learned` is low has no effect.
- R9: While `mode_fixed` and `locked` are both high, the outputs show the fixed registers and ignore any new decision made by the learner.
- R10: Any cycle with `mode_fixed` low clears `locked`. The outputs then show the learned values, and a later return to fixed mode stays unlocked until the next commit.
- R11: When a commit coincides with the clock edge at which the learner replaces its decision, the fixed registers receive the decision held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_valid | input | 1 | Code groups on all lanes are valid this cycle |
| lane_cg | input | 10*NUM_LANES | Aligned code groups, physical lane p at bits [10p+9:10p] |
| width | input | $clog2(NUM_LANES+1) | Number of active lanes (1 to NUM_LANES) |
| mode_fixed | input | 1 | 1 selects the fixed configuration, 0 selects auto |
| commit | input | 1 | Freeze the learned decision into the fixed registers |
| pol_mask | output | NUM_LANES | Polarity inversion per physical lane |
| reversed | output | 1 | Lane order is reversed |
| learned | output | 1 | A decision has been learned |
| locked | output | 1 | The fixed configuration holds a committed decision |

## Verification
Two events can land on the same clock edge: a commit, and the learner replacing its decision at the end of a new run. To force the overlap, the bench raises `commit` in the cycle after the final group of the last set in that run has been driven, because that is the edge at which the new decision is registered. The result is judged in two steps. In fixed mode the outputs must still show the older decision. After switching to auto, the outputs must show the newer decision, which proves the learner itself did move on.

// File: rtl/lcl_pkg.sv
package lcl_pkg;

    localparam int CG_W = 10;

    localparam logic [CG_W-1:0] COMMA_CG  = 10'b0011111010;
    localparam logic [CG_W-1:0] TS1_ID_CG = 10'b0101010101;
    localparam logic [CG_W-1:0] TS2_ID_CG = 10'b1010010101;
    localparam logic [4:0]      LANE_TAG  = 5'b10100;

    typedef enum logic [1:0] {
        ID_NONE = 2'd0,
        ID_TS1  = 2'd1,
        ID_TS2  = 2'd2
    } id_kind_e;

    typedef struct packed {
        id_kind_e kind;
        logic     inv;
    } id_cls_t;

    typedef struct packed {
        logic       done;
        logic       bad;
        logic       ts2;
        logic       inv;
        logic [4:0] lane_num;
    } set_rpt_t;

    function automatic logic is_comma(input logic [CG_W-1:0] cg);
        return (cg == COMMA_CG) || (cg == ~COMMA_CG);
    endfunction

    function automatic id_cls_t classify_id(input logic [CG_W-1:0] cg);
        id_cls_t r;
        r.kind = ID_NONE;
        r.inv  = 1'b0;
        if (cg == TS1_ID_CG) begin
            r.kind = ID_TS1;
        end else if (cg == ~TS1_ID_CG) begin
            r.kind = ID_TS1;
            r.inv  = 1'b1;
        end else if (cg == TS2_ID_CG) begin
            r.kind = ID_TS2;
        end else if (cg == ~TS2_ID_CG) begin
            r.kind = ID_TS2;
            r.inv  = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lcl_lane_track.sv
module lcl_lane_track
    import lcl_pkg::*;
#(
    parameter int TS_LEN = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cg_valid,
    input  logic [CG_W-1:0] cg,
    output set_rpt_t        rpt
);
    localparam int PW = $clog2(TS_LEN);

    logic            in_set;
    logic [PW-1:0]   pos;
    logic [CG_W-1:0] lane_raw;
    id_cls_t         id_first;
    id_cls_t         cur_cls;
    logic [CG_W-1:0] lane_fix;

    always_comb begin
        cur_cls  = classify_id(cg);
        lane_fix = cur_cls.inv ? ~lane_raw : lane_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_set   <= 1'b0;
            pos      <= '0;
            lane_raw <= '0;
            id_first <= '0;
            rpt      <= '0;
        end else begin
            rpt.done <= 1'b0;
            rpt.bad  <= 1'b0;
            if (cg_valid) begin
                if (is_comma(cg)) begin
                    rpt.bad <= in_set;
                    in_set  <= 1'b1;
                    pos     <= PW'(1);
                end else if (in_set) begin
                    if (pos == PW'(1)) begin
                        lane_raw <= cg;
                        pos      <= PW'(2);
                    end else if (cur_cls.kind == ID_NONE ||
                                 (pos != PW'(2) && cur_cls != id_first)) begin
                        rpt.bad <= 1'b1;
                        in_set  <= 1'b0;
                    end else begin
                        if (pos == PW'(2)) begin
                            id_first <= cur_cls;
                        end
                        if (pos == PW'(TS_LEN-1)) begin
                            in_set <= 1'b0;
                            if (lane_fix[9:5] != LANE_TAG) begin
                                rpt.bad <= 1'b1;
                            end else begin
                                rpt.done     <= 1'b1;
                                rpt.ts2      <= (cur_cls.kind == ID_TS2);
                                rpt.inv      <= cur_cls.inv;
                                rpt.lane_num <= lane_fix[4:0];
                            end
                        end else begin
                            pos <= pos + PW'(1);
                        end
                    end
                end
            end
        end
    end

    AST_DONE_XOR_BAD: assert property (@(posedge clk) disable iff (rst)
        !(rpt.done && rpt.bad)); // R6

    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (rst)
        rpt.done |=> !rpt.done); // R2

endmodule

// File: rtl/lcl_learn_core.sv
module lcl_learn_core
    import lcl_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int RUN_LEN   = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  set_rpt_t                         rpt [NUM_LANES],
    input  logic [$clog2(NUM_LANES+1)-1:0]   width,
    output logic [NUM_LANES-1:0]             lrn_pol,
    output logic                             lrn_rev,
    output logic                             learned
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [NUM_LANES-1:0] active, done_v, bad_v, ts2_v, inv_v, num_ok;
    logic [NUM_LANES-1:0] cand_pol, new_pol;
    logic                 cand_rev, new_rev;
    logic [CW-1:0]        run_cnt, cnt_nx;
    logic                 load_cand, good_set;
    logic                 evt, all_done, all_ts2, no_ts2, match;
    logic [4:0]           top_lane;

    always_comb begin
        top_lane = 5'(width) - 5'd1;
        new_rev  = (rpt[0].lane_num != 5'd0);
        for (int i = 0; i < NUM_LANES; i++) begin
            active[i] = (i < int'(width));
            done_v[i] = rpt[i].done;
            bad_v[i]  = rpt[i].bad;
            ts2_v[i]  = rpt[i].ts2;
            inv_v[i]  = rpt[i].inv;
            num_ok[i] = !active[i] ||
                        (rpt[i].lane_num == (new_rev ? top_lane - 5'(i) : 5'(i)));
        end
        new_pol  = inv_v & active;
        evt      = |((done_v | bad_v) & active);
        all_done = ((done_v & active) == active) && !(|(bad_v & active));
        all_ts2  = ((ts2_v & active) == active);
        no_ts2   = ((ts2_v & active) == '0);
        match    = (run_cnt != '0) && (new_pol == cand_pol) && (new_rev == cand_rev);

        cnt_nx    = run_cnt;
        load_cand = 1'b0;
        good_set  = 1'b0;
        if (evt) begin
            if (!all_done || (!all_ts2 && !no_ts2)) begin
                cnt_nx = '0;
            end else if (no_ts2) begin
                cnt_nx = run_cnt;
            end else if (!(&num_ok)) begin
                cnt_nx = '0;
            end else begin
                good_set = 1'b1;
                if (match) begin
                    cnt_nx = (run_cnt == CW'(RUN_LEN)) ? run_cnt : run_cnt + CW'(1);
                end else begin
                    load_cand = 1'b1;
                    cnt_nx    = CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            cand_pol <= '0;
            cand_rev <= 1'b0;
            lrn_pol  <= '0;
            lrn_rev  <= 1'b0;
            learned  <= 1'b0;
        end else begin
            run_cnt <= cnt_nx;
            if (load_cand) begin
                cand_pol <= new_pol;
                cand_rev <= new_rev;
            end
            if (good_set && cnt_nx == CW'(RUN_LEN)) begin
                learned <= 1'b1;
                lrn_pol <= new_pol;
                lrn_rev <= new_rev;
            end
        end
    end

    AST_LEARNED_STICKY: assert property (@(posedge clk) disable iff (rst)
        learned |=> learned); // R7

    AST_LEARN_AT_RUN_END: assert property (@(posedge clk) disable iff (rst)
        $rose(learned) |-> run_cnt == CW'(RUN_LEN)); // R5

    AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CW'(RUN_LEN)); // R5

endmodule

// File: rtl/lcl_cfg_hold.sv
module lcl_cfg_hold #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_fixed,
    input  logic                 commit,
    input  logic                 learned,
    input  logic [NUM_LANES-1:0] lrn_pol,
    input  logic                 lrn_rev,
    output logic [NUM_LANES-1:0] pol_mask,
    output logic                 reversed,
    output logic                 locked
);
    logic [NUM_LANES-1:0] fix_pol;
    logic                 fix_rev;
    logic                 take, use_fix;

    always_comb begin
        take     = mode_fixed && commit && learned;
        use_fix  = mode_fixed && locked;
        pol_mask = use_fix ? fix_pol : lrn_pol;
        reversed = use_fix ? fix_rev : lrn_rev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_pol <= '0;
            fix_rev <= 1'b0;
            locked  <= 1'b0;
        end else begin
            if (take) begin
                fix_pol <= lrn_pol;
                fix_rev <= lrn_rev;
            end
            if (!mode_fixed) begin
                locked <= 1'b0;
            end else if (take) begin
                locked <= 1'b1;
            end
        end
    end

    AST_AUTO_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        !mode_fixed |=> !locked); // R10

    AST_COMMIT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (mode_fixed && commit && learned) |=> locked); // R8

    AST_LOCK_NEEDS_LEARN: assert property (@(posedge clk) disable iff (rst)
        locked |-> learned); // R8

    AST_FIXED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (use_fix && $past(use_fix && !commit)) |-> ($stable(pol_mask) && $stable(reversed))); // R9

endmodule

// File: rtl/lane_cfg_learner.sv
module lane_cfg_learner
    import lcl_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int TS_LEN    = 6,
    parameter int RUN_LEN   = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cg_valid,
    input  logic [NUM_LANES*CG_W-1:0]        lane_cg,
    input  logic [$clog2(NUM_LANES+1)-1:0]   width,
    input  logic                             mode_fixed,
    input  logic                             commit,
    output logic [NUM_LANES-1:0]             pol_mask,
    output logic                             reversed,
    output logic                             learned,
    output logic                             locked
);
    set_rpt_t             rpt [NUM_LANES];
    logic [NUM_LANES-1:0] lrn_pol;
    logic                 lrn_rev;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lcl_lane_track #(.TS_LEN(TS_LEN)) u_track (
            .clk      (clk),
            .rst      (rst),
            .cg_valid (cg_valid),
            .cg       (lane_cg[g*CG_W +: CG_W]),
            .rpt      (rpt[g])
        );
    end

    lcl_learn_core #(.NUM_LANES(NUM_LANES), .RUN_LEN(RUN_LEN)) u_core (
        .clk     (clk),
        .rst     (rst),
        .rpt     (rpt),
        .width   (width),
        .lrn_pol (lrn_pol),
        .lrn_rev (lrn_rev),
        .learned (learned)
    );

    lcl_cfg_hold #(.NUM_LANES(NUM_LANES)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .mode_fixed (mode_fixed),
        .commit     (commit),
        .learned    (learned),
        .lrn_pol    (lrn_pol),
        .lrn_rev    (lrn_rev),
        .pol_mask   (pol_mask),
        .reversed   (reversed),
        .locked     (locked)
    );

endmodule

// File: tb/tb_lane_cfg_learner.sv
module tb_lane_cfg_learner;
    localparam int NL  = 4;
    localparam int TSL = 6;
    localparam int WW  = $clog2(NL + 1);
    localparam logic [9:0] K_COMMA = 10'b0011111010;
    localparam logic [9:0] K_ID1   = 10'b0101010101;
    localparam logic [9:0] K_ID2   = 10'b1010010101;

    logic          clk = 1'b0;
    logic          rst;
    logic          cg_valid;
    logic [NL*10-1:0] lane_cg;
    logic [WW-1:0] width;
    logic          mode_fixed;
    logic          commit;
    logic [NL-1:0] pol_mask;
    logic          reversed, learned, locked;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lane_cfg_learner #(.NUM_LANES(NL), .TS_LEN(TSL), .RUN_LEN(8)) dut (
        .clk(clk), .rst(rst), .cg_valid(cg_valid), .lane_cg(lane_cg),
        .width(width), .mode_fixed(mode_fixed), .commit(commit),
        .pol_mask(pol_mask), .reversed(reversed), .learned(learned), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cg_valid = 1'b0;
            commit   = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cg_valid = 1'b0; lane_cg = '0; width = WW'(NL);
        mode_fixed = 1'b0; commit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_set(input bit ts2, input logic [NL-1:0] inv, input bit rev,
                            input int w, input int bad_lane = -1);
        for (int s = 0; s < TSL; s++) begin
            @(negedge clk);
            cg_valid = 1'b1;
            for (int p = 0; p < NL; p++) begin
                logic [9:0] c;
                if (p >= w) begin
                    c = 10'h000;
                end else begin
                    if (s == 0)      c = K_COMMA;
                    else if (s == 1) c = {5'b10100, 5'(rev ? (w - 1 - p) : p)};
                    else             c = ts2 ? K_ID2 : K_ID1;
                    if (p == bad_lane && s == 3) c = 10'h3FF;
                    if (inv[p]) c = ~c;
                end
                lane_cg[p*10 +: 10] = c;
            end
        end
    endtask

    task automatic run_sets(input int n, input logic [NL-1:0] inv, input bit rev, input int w);
        for (int i = 0; i < n; i++) send_set(1'b1, inv, rev, w);
    endtask

    task automatic pulse_commit();
        @(negedge clk); commit = 1'b1; cg_valid = 1'b0;
        @(negedge clk); commit = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pol_mask", 32'(pol_mask), 0);
        chk("R1 reversed", 32'(reversed), 0);
        chk("R1 learned", 32'(learned), 0);
        chk("R1 locked", 32'(locked), 0);
    endtask

    task automatic t_no_training();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cg_valid = 1'b1;
            lane_cg  = {NL{(i % 2 == 0) ? K_ID2 : 10'h0F3}};
        end
        idle(3);
        chk("R7 learned stays low", 32'(learned), 0);
        chk("R7 pol unchanged", 32'(pol_mask), 0);
    endtask

    task automatic t_basic();
        run_sets(7, 4'b0101, 1'b0, 4);
        idle(3);
        chk("R5 not after 7 sets", 32'(learned), 0);
        run_sets(1, 4'b0101, 1'b0, 4);
        idle(3);
        chk("R5 learned after 8 sets", 32'(learned), 1);
        chk("R3 pol_mask", 32'(pol_mask), 32'h5);
        chk("R4 not reversed", 32'(reversed), 0);
    endtask

    task automatic t_ts1_neutral();
        run_sets(4, 4'b0010, 1'b1, 4);
        for (int i = 0; i < 3; i++) send_set(1'b0, 4'b1100, 1'b0, 4);
        run_sets(3, 4'b0010, 1'b1, 4);
        idle(3);
        chk("R7 old decision kept", 32'(pol_mask), 32'h5);
        run_sets(1, 4'b0010, 1'b1, 4);
        idle(3);
        chk("R5 TS1 neutral pol", 32'(pol_mask), 32'h2);
        chk("R4 reversed", 32'(reversed), 1);
    endtask

    task automatic t_restart();
        run_sets(5, 4'b1000, 1'b0, 4);
        send_set(1'b1, 4'b1000, 1'b0, 4, 2);
        run_sets(7, 4'b1000, 1'b0, 4);
        idle(3);
        chk("R6 bad id restarts", 32'(pol_mask), 32'h2);
        run_sets(1, 4'b1000, 1'b0, 4);
        idle(3);
        chk("R6 run after restart", 32'(pol_mask), 32'h8);
        run_sets(4, 4'b0001, 1'b0, 4);
        run_sets(1, 4'b0011, 1'b0, 4);
        run_sets(7, 4'b0001, 1'b0, 4);
        idle(3);
        chk("R6 polarity change restarts", 32'(pol_mask), 32'h8);
        run_sets(1, 4'b0001, 1'b0, 4);
        idle(3);
        chk("R6 new run complete", 32'(pol_mask), 32'h1);
    endtask

    task automatic t_width();
        width = WW'(2);
        run_sets(8, 4'b1111, 1'b1, 2);
        idle(3);
        chk("R3 inactive bits zero", 32'(pol_mask), 32'h3);
        chk("R4 reversed at width 2", 32'(reversed), 1);
        width = WW'(1);
        run_sets(8, 4'b0001, 1'b0, 1);
        idle(3);
        chk("R4 width 1 not reversed", 32'(reversed), 0);
        chk("R3 width 1 pol", 32'(pol_mask), 32'h1);
        width = WW'(4);
    endtask

    task automatic t_commit_unlearned();
        do_reset();
        mode_fixed = 1'b1;
        pulse_commit();
        chk("R8 commit ignored unlearned", 32'(locked), 0);
    endtask

    task automatic t_fixed();
        run_sets(8, 4'b0110, 1'b0, 4);
        idle(3);
        pulse_commit();
        chk("R8 locked after commit", 32'(locked), 1);
        chk("R8 fixed pol", 32'(pol_mask), 32'h6);
        run_sets(8, 4'b1001, 1'b1, 4);
        idle(3);
        chk("R9 fixed pol held", 32'(pol_mask), 32'h6);
        chk("R9 fixed rev held", 32'(reversed), 0);
        @(negedge clk); mode_fixed = 1'b0;
        @(negedge clk);
        chk("R10 auto clears lock", 32'(locked), 0);
        chk("R10 auto shows learned pol", 32'(pol_mask), 32'h9);
        chk("R10 auto shows learned rev", 32'(reversed), 1);
        mode_fixed = 1'b1;
        @(negedge clk);
        chk("R10 stays unlocked", 32'(locked), 0);
    endtask

    task automatic t_collision();
        run_sets(7, 4'b0100, 1'b0, 4);
        send_set(1'b1, 4'b0100, 1'b0, 4);
        @(negedge clk); cg_valid = 1'b0; commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        idle(2);
        chk("R11 locked on collision", 32'(locked), 1);
        chk("R11 fixed keeps older pol", 32'(pol_mask), 32'h9);
        chk("R11 fixed keeps older rev", 32'(reversed), 1);
        mode_fixed = 1'b0;
        @(negedge clk);
        chk("R11 learner moved on", 32'(pol_mask), 32'h4);
    endtask

    initial begin
        rst = 1'b1; cg_valid = 1'b0; lane_cg = '0; width = WW'(NL);
        mode_fixed = 1'b0; commit = 1'b0;
        t_reset();
        t_no_training();
        t_basic();
        t_ts1_neutral();
        t_restart();
        t_width();
        t_commit_unlearned();
        t_fixed();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule